// File: doc/BRIEF.md
# Count/Compare Timer with Interrupt

This block keeps a 32-bit up-counter and a 32-bit compare value. Each clock in which the tick-enable input is high, the counter steps by one, so it can run at the core clock or at a fraction of it. When a step brings the counter onto the compare value, the block raises its timer interrupt, the request that feeds hardware interrupt line 7 of the core. The request stays high until software writes the compare value again. That write is the only acknowledge.

A configuration input selects the newer architectural revision. In that mode a timer-pending flag in the cause word follows the interrupt. A count-disable bit in the cause word can also be set by software to freeze the counter. In the older mode the count-disable bit cannot be written and always reads zero, and the pending flag is never set. The cause word produced here carries only these two fields. The core merges them into its full cause register.

Top module: `cc_timer`

## Requirements
- R1: After reset, the count and compare values are 0, the interrupt is low, and both cause fields are 0.
- R2: In a cycle with tick_en high, the count-disable bit clear and no count write, the count rises by one on the next clock edge. It holds when tick_en is low, and it wraps from 0xFFFFFFFF to 0.
- R3: While the count-disable bit (cause bit 27) is set, the count does not advance, whatever tick_en is.
- R4: A cause write loads wdata bit 27 into the count-disable bit only when cfg_rev2 is high. With cfg_rev2 low the bit stays 0.
- R5: When an advance brings the count onto the compare value, timer_irq goes high on the same edge that the count takes that value. It then stays high until a compare write.
- R6: With cfg_rev2 high, the timer-pending flag (cause bit 30) is set together with timer_irq. With cfg_rev2 low it stays 0.
- R7: Any compare write loads the new compare value and clears timer_irq and the pending flag on the next edge. It wins over a match in the same cycle.
- R8: A count write loads its value on the next edge and wins over an advance in that cycle. It does not clear a pending interrupt, and it does not raise a match by itself.
- R9: cause_o carries the pending flag at bit 30 and the count-disable bit at bit 27. All its other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rev2 | input | 1 | Selects revision-2 behaviour; a static strap |
| tick_en | input | 1 | Count advance enable |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | 32 | Count write value |
| cmp_we | input | 1 | Compare write strobe (acknowledge) |
| cmp_wdata | input | 32 | Compare write value |
| cause_we | input | 1 | Cause write strobe |
| cause_wdata | input | 32 | Cause write value; only bit 27 is used |
| count_o | output | 32 | Current count |
| compare_o | output | 32 | Current compare value |
| cause_o | output | 32 | Timer fields of the cause word |
| timer_irq | output | 1 | Timer interrupt request for line 7 |

## Verification
The assertions assume that cfg_rev2 changes only while reset is held. Under that assumption the pending flag can be tied to the interrupt in revision-2 mode and held at zero otherwise. The bench changes the strap only inside its reset sequence. Each configuration then gets its own stretch of operation, with the write strobes and tick_en driven as single-cycle pulses on the falling edge. A behavioural model runs beside the design and is compared with it on every clock.

// File: rtl/cc_timer.sv
module cc_timer #(
  parameter int CNT_W   = 32,
  parameter int CAUSE_W = 32,
  parameter int TI_POS  = 30,
  parameter int DC_POS  = 27
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_rev2,
  input  logic               tick_en,
  input  logic               cnt_we,
  input  logic [CNT_W-1:0]   cnt_wdata,
  input  logic               cmp_we,
  input  logic [CNT_W-1:0]   cmp_wdata,
  input  logic               cause_we,
  input  logic [CAUSE_W-1:0] cause_wdata,
  output logic [CNT_W-1:0]   count_o,
  output logic [CNT_W-1:0]   compare_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               timer_irq
);
  localparam logic [CNT_W-1:0] ONE = 1;

  logic [CNT_W-1:0] count_q, compare_q, count_inc;
  logic irq_q, ti_q, dc_q, advance, hit;

  assign count_inc = count_q + ONE;
  assign advance   = tick_en & ~dc_q & ~cnt_we;
  assign hit       = advance & (count_inc == compare_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q   <= '0;
      compare_q <= '0;
    end else begin
      if (cnt_we)       count_q <= cnt_wdata;
      else if (advance) count_q <= count_inc;
      if (cmp_we)       compare_q <= cmp_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      ti_q  <= 1'b0;
    end else if (cmp_we) begin
      irq_q <= 1'b0;
      ti_q  <= 1'b0;
    end else if (hit) begin
      irq_q <= 1'b1;
      ti_q  <= cfg_rev2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  dc_q <= 1'b0;
    else if (cause_we && cfg_rev2) dc_q <= cause_wdata[DC_POS];
  end

  always_comb begin
    cause_o         = '0;
    cause_o[TI_POS] = ti_q;
    cause_o[DC_POS] = dc_q;
  end

  assign count_o   = count_q;
  assign compare_o = compare_q;
  assign timer_irq = irq_q;
endmodule

// File: rtl/cc_timer_chk.sv
module cc_timer_chk #(
  parameter int CNT_W   = 32,
  parameter int CAUSE_W = 32,
  parameter int TI_POS  = 30,
  parameter int DC_POS  = 27
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_rev2,
  input logic               tick_en,
  input logic               cnt_we,
  input logic [CNT_W-1:0]   cnt_wdata,
  input logic               cmp_we,
  input logic               cause_we,
  input logic [CNT_W-1:0]   count_o,
  input logic [CNT_W-1:0]   compare_o,
  input logic [CAUSE_W-1:0] cause_o,
  input logic               timer_irq
);
  localparam logic [CNT_W-1:0] ONE = 1;
  logic [CNT_W-1:0] nxt;
  logic dc, ti;
  assign nxt = count_o + ONE;
  assign dc  = cause_o[DC_POS];
  assign ti  = cause_o[TI_POS];

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !dc && !cnt_we) |=> (count_o == $past(nxt))); // R2
  AST_DC_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (dc && !cnt_we) |=> $stable(count_o)); // R3
  AST_DC_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rev2 |-> !dc); // R4
  AST_MATCH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !dc && !cnt_we && !cmp_we && nxt == compare_o) |=> timer_irq); // R5
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_irq && !cmp_we) |=> timer_irq); // R5
  AST_TI_REV2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rev2 |-> (ti == timer_irq)); // R6
  AST_TI_REV1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rev2 |-> !ti); // R6
  AST_CMP_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we |=> (!timer_irq && !ti)); // R7
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (count_o == $past(cnt_wdata))); // R8
  AST_CAUSE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cause_o) == $countones({ti, dc})); // R9
endmodule

bind cc_timer cc_timer_chk #(.CNT_W(CNT_W), .CAUSE_W(CAUSE_W), .TI_POS(TI_POS), .DC_POS(DC_POS)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_rev2(cfg_rev2), .tick_en(tick_en),
  .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cmp_we(cmp_we), .cause_we(cause_we),
  .count_o(count_o), .compare_o(compare_o), .cause_o(cause_o), .timer_irq(timer_irq));

// File: tb/cc_timer_tb_top.sv
`timescale 1ns/1ps
module cc_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_rev2 = 1'b0, tick_en = 1'b0, cnt_we = 1'b0, cmp_we = 1'b0, cause_we = 1'b0;
  logic [31:0] cnt_wdata = '0, cmp_wdata = '0, cause_wdata = '0;
  logic [31:0] count_o, compare_o, cause_o;
  logic timer_irq;

  always #2 clk = ~clk;

  cc_timer dut_i (.clk(clk), .rst_n(rst_n), .cfg_rev2(cfg_rev2), .tick_en(tick_en),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .cause_we(cause_we), .cause_wdata(cause_wdata), .count_o(count_o),
    .compare_o(compare_o), .cause_o(cause_o), .timer_irq(timer_irq));

  int total = 0, fails = 0;
  bit [31:0] m_cnt, m_cmp;
  bit m_irq, m_ti, m_dc;

  task automatic check(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R2 count", count_o, m_cnt);
    check("R7 compare", compare_o, m_cmp);
    check("R5 irq", timer_irq, m_irq);
    check("R9 cause", cause_o, (longint'(m_ti) << 30) | (longint'(m_dc) << 27));
  endtask

  task automatic step();
    bit adv, hit;
    @(posedge clk);
    adv = tick_en && !m_dc && !cnt_we;
    hit = adv && (m_cnt + 32'd1 == m_cmp);
    if (cmp_we) begin m_irq = 0; m_ti = 0; end
    else if (hit) begin m_irq = 1; m_ti = cfg_rev2; end
    if (cnt_we) m_cnt = cnt_wdata; else if (adv) m_cnt = m_cnt + 32'd1;
    if (cmp_we) m_cmp = cmp_wdata;
    if (cause_we && cfg_rev2) m_dc = cause_wdata[27];
    @(negedge clk);
    compare_all();
    cnt_we = 0; cmp_we = 0; cause_we = 0;
  endtask

  task automatic run(int n, bit half);
    for (int i = 0; i < n; i++) begin
      tick_en = half ? i[0] : 1'b1;
      step();
    end
    tick_en = 0;
  endtask

  task automatic do_reset(bit rev2);
    @(negedge clk);
    rst_n = 0; cfg_rev2 = rev2; tick_en = 0;
    m_cnt = 0; m_cmp = 0; m_irq = 0; m_ti = 0; m_dc = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    check("R1 reset count", count_o, 0);
    check("R1 reset irq", timer_irq, 0);
    check("R1 reset cause", cause_o, 0);
  endtask

  task automatic wr_cnt(logic [31:0] v); cnt_we = 1; cnt_wdata = v; step(); endtask
  task automatic wr_cmp(logic [31:0] v); cmp_we = 1; cmp_wdata = v; step(); endtask
  task automatic wr_cause(logic [31:0] v); cause_we = 1; cause_wdata = v; step(); endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    // older revision, half-rate ticking
    wr_cmp(32'd10);
    run(30, 1'b1);
    check("R5 irq after match", timer_irq, 1);
    check("R6 no TI on rev1", cause_o[30], 0);
    wr_cnt(32'd3);
    check("R8 count write keeps irq", timer_irq, 1);
    check("R8 count loaded", count_o, 3);
    wr_cmp(32'd50);
    check("R7 ack clears irq", timer_irq, 0);
    wr_cause(32'h0800_0000);
    check("R4 DC locked on rev1", cause_o[27], 0);
    run(5, 1'b0);
    check("R4 count still runs", count_o, 8);
    // count write landing on compare value: no match
    wr_cnt(32'd50);
    check("R8 write to compare value no irq", timer_irq, 0);

    do_reset(1'b1);
    wr_cause(32'h0800_0000);
    check("R4 DC set on rev2", cause_o[27], 1);
    run(6, 1'b0);
    check("R3 frozen", count_o, 0);
    wr_cause(32'h0);
    wr_cmp(32'd4);
    run(6, 1'b0);
    check("R6 TI with irq", cause_o[30], 1);
    check("R5 irq rev2", timer_irq, 1);
    wr_cmp(32'd100);
    check("R7 TI cleared", cause_o[30], 0);
    // wrap
    wr_cnt(32'hFFFF_FFFE);
    wr_cmp(32'd1);
    run(2, 1'b0);
    check("R2 wrap to zero", count_o, 0);
    check("R5 not yet", timer_irq, 0);
    run(1, 1'b0);
    check("R5 irq at wrap match", timer_irq, 1);
    // simultaneous match and compare write
    wr_cmp(32'd6);
    wr_cnt(32'd5);
    tick_en = 1; cmp_we = 1; cmp_wdata = 32'd200; step(); tick_en = 0;
    check("R7 ack wins over match", timer_irq, 0);
    check("R7 count advanced", count_o, 6);
    // count write wins over advance
    tick_en = 1; cnt_we = 1; cnt_wdata = 32'd77; step(); tick_en = 0;
    check("R8 write wins", count_o, 77);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule